// File: doc/BRIEF.md
# Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core. The lower eight exist twice, once in bank 0 and once in bank 1. The upper eight have one copy that both banks share. Two combinational read ports and one write port serve normal instruction traffic. A separate alternate-bank port lets a control-register move reach the lower eight registers of the bank that is not currently selected. A dedicated index output always presents R0 of the current view, so the address path can use it for indexed addressing.

The bank-select bit and the privileged-mode input are sampled into a small view state machine, so a change takes effect one cycle later. The machine has three states. VIEW_USER maps normal accesses to bank 0 and refuses alternate-bank traffic. VIEW_BANK0 is privileged mode with bank 0 as the working bank. VIEW_BANK1 is privileged mode with bank 1 as the working bank. There are four kinds of transition:
- T_DROP goes from any state to VIEW_USER when privileged mode is low.
- T_ENTER0 and T_ENTER1 leave VIEW_USER for the bank that the select bit names.
- T_SWAP moves between VIEW_BANK0 and VIEW_BANK1 when the select bit changes while privileged mode stays high.
- T_HOLD keeps the current state.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears all 24 physical registers to zero and puts the view in VIEW_USER.
- R2: Reads are combinational. A normal write lands at the next rising edge, so a read of the same register in the write cycle returns the old value and the cycle after returns the new one.
- R3: In privileged mode with the select bit at 1, normal accesses to indices 0–7 reach bank 1, and the alternate-bank port reaches bank 0.
- R4: In privileged mode with the select bit at 0, normal accesses to indices 0–7 reach bank 0, and the alternate-bank port reaches bank 1.
- R5: In user mode, normal accesses to indices 0–7 use bank 0 whatever the select bit says.
- R6: In user mode, an alternate-bank access (enable at 1) has no effect. It raises `alt_illegal_o`, an alternate write is discarded, and `alt_rdata_o` reads 0. `alt_rdata_o` also reads 0 whenever the alternate port's enable is 0.
- R7: Indices 8–15 address one shared copy. A normal write or read there reaches the same storage whatever the bank state is.
- R8: `index_o` always equals the value that a normal read of index 0 would return in the same cycle.
- R9: Changes on `priv_i` and `bank_sel_i` take effect only from the cycle after the edge that samples them. Accesses in the cycle of a change still use the old view.
- R10: A legal alternate-bank write, selected by a 3-bit index of 0–7, takes effect at the next rising edge in the non-selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| priv_i | input | 1 | Privileged mode when 1 |
| bank_sel_i | input | 1 | Bank-select bit from the status register |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Normal write enable |
| wr_idx_i | input | 4 | Normal write register index |
| wr_data_i | input | 32 | Normal write data |
| index_o | output | 32 | R0 of the current view |
| alt_en_i | input | 1 | Alternate-bank access request |
| alt_we_i | input | 1 | Alternate-bank write when 1, read otherwise |
| alt_idx_i | input | 3 | Alternate-bank register index (0–7) |
| alt_wdata_i | input | 32 | Alternate-bank write data |
| alt_rdata_o | output | 32 | Alternate-bank read data |
| alt_illegal_o | output | 1 | Alternate access attempted in user mode |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight banked registers and eight shared registers. With these defaults the full 4-bit index space, all 24 physical registers and every view state and transition can be reached by a few thousand random cycles. Directed cases cover the edge-delayed bank switch, the user-mode fallback to bank 0 and the write-then-read timing on both the normal and the alternate port.

// File: rtl/bgrf_pkg.sv
package bgrf_pkg;

    typedef enum logic [1:0] {
        VIEW_USER  = 2'd0,
        VIEW_BANK0 = 2'd1,
        VIEW_BANK1 = 2'd2
    } view_e;

endpackage

// File: rtl/bgrf_view_fsm.sv
module bgrf_view_fsm
    import bgrf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic priv_i,
    input  logic bank_sel_i,
    output logic cur_bank_o,
    output logic alt_ok_o
);

    view_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= VIEW_USER;
        else       state_q <= state_d;
    end

    // Next state: T_DROP, T_ENTER0/1, T_SWAP, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIEW_USER: begin
                if (priv_i) state_d = bank_sel_i ? VIEW_BANK1 : VIEW_BANK0;
            end
            VIEW_BANK0: begin
                if (!priv_i)        state_d = VIEW_USER;
                else if (bank_sel_i) state_d = VIEW_BANK1;
            end
            VIEW_BANK1: begin
                if (!priv_i)         state_d = VIEW_USER;
                else if (!bank_sel_i) state_d = VIEW_BANK0;
            end
            default: state_d = VIEW_USER;
        endcase
    end

    // Outputs
    always_comb begin
        cur_bank_o = 1'b0;
        alt_ok_o   = 1'b0;
        unique case (state_q)
            VIEW_USER:  begin cur_bank_o = 1'b0; alt_ok_o = 1'b0; end
            VIEW_BANK0: begin cur_bank_o = 1'b0; alt_ok_o = 1'b1; end
            VIEW_BANK1: begin cur_bank_o = 1'b1; alt_ok_o = 1'b1; end
            default:    begin cur_bank_o = 1'b0; alt_ok_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bgrf_storage.sv
module bgrf_storage #(
    parameter int DW = 32,
    parameter int NB = 8,
    parameter int NS = 8,
    localparam int RW = $clog2(NB + NS),
    localparam int AW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          cur_bank_i,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          alt_wr_i,
    input  logic [AW-1:0] alt_idx_i,
    input  logic [DW-1:0] alt_wdata_i,
    output logic [DW-1:0] bank0_o  [NB],
    output logic [DW-1:0] bank1_o  [NB],
    output logic [DW-1:0] shared_o [NS]
);

    for (genvar i = 0; i < NB; i++) begin : g_banked
        logic [DW-1:0] b0_q, b1_q;
        logic norm_hit, alt_hit;
        assign norm_hit = wr_en_i && (wr_idx_i == RW'(i));
        assign alt_hit  = alt_wr_i && (alt_idx_i == AW'(i));

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                b0_q <= '0;
                b1_q <= '0;
            end else begin
                if (norm_hit && !cur_bank_i)    b0_q <= wr_data_i;
                else if (alt_hit && cur_bank_i) b0_q <= alt_wdata_i;
                if (norm_hit && cur_bank_i)      b1_q <= wr_data_i;
                else if (alt_hit && !cur_bank_i) b1_q <= alt_wdata_i;
            end
        end
        assign bank0_o[i] = b0_q;
        assign bank1_o[i] = b1_q;
    end

    for (genvar j = 0; j < NS; j++) begin : g_shared
        logic [DW-1:0] s_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)                                    s_q <= '0;
            else if (wr_en_i && (wr_idx_i == RW'(NB + j))) s_q <= wr_data_i;
        end
        assign shared_o[j] = s_q;
    end

endmodule

// File: rtl/bgrf_read_mux.sv
module bgrf_read_mux #(
    parameter int DW = 32,
    parameter int NB = 8,
    parameter int NS = 8,
    localparam int RW = $clog2(NB + NS),
    localparam int AW = (NB > 1) ? $clog2(NB) : 1,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [RW-1:0] idx_i,
    input  logic          cur_bank_i,
    input  logic [DW-1:0] bank0_i  [NB],
    input  logic [DW-1:0] bank1_i  [NB],
    input  logic [DW-1:0] shared_i [NS],
    output logic [DW-1:0] data_o
);

    logic [RW-1:0] sh_off;
    assign sh_off = idx_i - RW'(NB);

    always_comb begin
        data_o = '0;
        if (int'(idx_i) < NB)
            data_o = cur_bank_i ? bank1_i[AW'(idx_i)] : bank0_i[AW'(idx_i)];
        else if (int'(idx_i) < NB + NS)
            data_o = shared_i[SW'(sh_off)];
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int DW = 32,
    parameter int NB = 8,
    parameter int NS = 8,
    localparam int RW = $clog2(NB + NS),
    localparam int AW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          priv_i,
    input  logic          bank_sel_i,
    input  logic [RW-1:0] rd_a_idx_i,
    output logic [DW-1:0] rd_a_data_o,
    input  logic [RW-1:0] rd_b_idx_i,
    output logic [DW-1:0] rd_b_data_o,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] index_o,
    input  logic          alt_en_i,
    input  logic          alt_we_i,
    input  logic [AW-1:0] alt_idx_i,
    input  logic [DW-1:0] alt_wdata_i,
    output logic [DW-1:0] alt_rdata_o,
    output logic          alt_illegal_o
);

    logic          cur_bank, alt_ok, alt_wr;
    logic [DW-1:0] bank0  [NB];
    logic [DW-1:0] bank1  [NB];
    logic [DW-1:0] shared [NS];
    logic [RW-1:0] rd_idx [3];
    logic [DW-1:0] rd_dat [3];
    logic [DW-1:0] alt_raw;

    bgrf_view_fsm u_view (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .priv_i     (priv_i),
        .bank_sel_i (bank_sel_i),
        .cur_bank_o (cur_bank),
        .alt_ok_o   (alt_ok)
    );

    assign alt_wr = alt_en_i && alt_we_i && alt_ok;

    bgrf_storage #(.DW(DW), .NB(NB), .NS(NS)) u_store (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cur_bank_i  (cur_bank),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i),
        .alt_wr_i    (alt_wr),
        .alt_idx_i   (alt_idx_i),
        .alt_wdata_i (alt_wdata_i),
        .bank0_o     (bank0),
        .bank1_o     (bank1),
        .shared_o    (shared)
    );

    // Port 0: read A, port 1: read B, port 2: index output (fixed R0)
    assign rd_idx[0] = rd_a_idx_i;
    assign rd_idx[1] = rd_b_idx_i;
    assign rd_idx[2] = '0;

    for (genvar p = 0; p < 3; p++) begin : g_rd
        bgrf_read_mux #(.DW(DW), .NB(NB), .NS(NS)) u_mux (
            .idx_i      (rd_idx[p]),
            .cur_bank_i (cur_bank),
            .bank0_i    (bank0),
            .bank1_i    (bank1),
            .shared_i   (shared),
            .data_o     (rd_dat[p])
        );
    end

    assign rd_a_data_o = rd_dat[0];
    assign rd_b_data_o = rd_dat[1];
    assign index_o     = rd_dat[2];

    assign alt_raw       = cur_bank ? bank0[alt_idx_i] : bank1[alt_idx_i];
    assign alt_rdata_o   = (alt_en_i && alt_ok) ? alt_raw : '0;
    assign alt_illegal_o = alt_en_i && !alt_ok;

endmodule

// File: rtl/bgrf_chk.sv
module bgrf_chk #(
    parameter int DW = 32,
    parameter int NB = 8,
    parameter int NS = 8,
    localparam int RW = $clog2(NB + NS),
    localparam int AW = (NB > 1) ? $clog2(NB) : 1
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          priv_i,
    input logic          bank_sel_i,
    input logic [RW-1:0] rd_a_idx_i,
    input logic [DW-1:0] rd_a_data_o,
    input logic [RW-1:0] rd_b_idx_i,
    input logic [DW-1:0] rd_b_data_o,
    input logic          wr_en_i,
    input logic [RW-1:0] wr_idx_i,
    input logic [DW-1:0] wr_data_i,
    input logic [DW-1:0] index_o,
    input logic          alt_en_i,
    input logic          alt_we_i,
    input logic [AW-1:0] alt_idx_i,
    input logic [DW-1:0] alt_wdata_i,
    input logic [DW-1:0] alt_rdata_o,
    input logic          alt_illegal_o
);

    logic started;
    always_ff @(posedge clk_i) begin
        if (rst_i) started <= 1'b0;
        else       started <= 1'b1;
    end

    // R6
    illegal_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        started |-> (alt_illegal_o == (alt_en_i && !$past(priv_i))));

    // R6
    illegal_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        alt_illegal_o |-> (alt_rdata_o == '0));

    // R8
    index_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_a_idx_i == '0) |-> (index_o == rd_a_data_o));

    // R7
    shared_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && int'(wr_idx_i) >= NB && int'(wr_idx_i) < NB + NS)
        |=> ((rd_b_idx_i != $past(wr_idx_i)) || (rd_b_data_o == $past(wr_data_i))));

    // R2
    port_agree_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));

endmodule

bind banked_regfile bgrf_chk #(.DW(DW), .NB(NB), .NS(NS)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .priv_i        (priv_i),
    .bank_sel_i    (bank_sel_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_idx_i    (rd_b_idx_i),
    .rd_b_data_o   (rd_b_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .index_o       (index_o),
    .alt_en_i      (alt_en_i),
    .alt_we_i      (alt_we_i),
    .alt_idx_i     (alt_idx_i),
    .alt_wdata_i   (alt_wdata_i),
    .alt_rdata_o   (alt_rdata_o),
    .alt_illegal_o (alt_illegal_o)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_i, priv_i, bank_sel_i;
    logic [3:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
    logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i, index_o;
    logic        wr_en_i, alt_en_i, alt_we_i, alt_illegal_o;
    logic [2:0]  alt_idx_i;
    logic [31:0] alt_wdata_i, alt_rdata_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_sh [8];
    bit m_priv, m_bank;

    always #5 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk_i(clk), .rst_i(rst_i), .priv_i(priv_i), .bank_sel_i(bank_sel_i),
        .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .index_o(index_o), .alt_en_i(alt_en_i), .alt_we_i(alt_we_i),
        .alt_idx_i(alt_idx_i), .alt_wdata_i(alt_wdata_i),
        .alt_rdata_o(alt_rdata_o), .alt_illegal_o(alt_illegal_o)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] idx);
        if (idx < 8) return (m_priv && m_bank) ? m_b1[idx[2:0]] : m_b0[idx[2:0]];
        return m_sh[idx[2:0]];
    endfunction

    function automatic logic [31:0] exp_alt();
        if (!(alt_en_i && m_priv)) return 32'h0;
        return m_bank ? m_b0[alt_idx_i] : m_b1[alt_idx_i];
    endfunction

    function automatic string auto_tag(input logic [3:0] idx);
        if (idx >= 8)  return "R7";
        if (!m_priv)   return "R5";
        return m_bank ? "R3" : "R4";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        string ta, tb, tx;
        ta = (tag == "") ? auto_tag(rd_a_idx_i) : tag;
        tb = (tag == "") ? auto_tag(rd_b_idx_i) : tag;
        tx = (tag == "") ? (m_priv ? (m_bank ? "R3" : "R4") : "R6") : tag;
        chk(ta, rd_a_data_o, exp_read(rd_a_idx_i));
        chk(tb, rd_b_data_o, exp_read(rd_b_idx_i));
        chk((tag == "") ? "R8" : tag, index_o, exp_read(4'd0));
        chk(tx, alt_rdata_o, exp_alt());
        chk((tag == "") ? "R6" : tag, {31'd0, alt_illegal_o}, {31'd0, alt_en_i && !m_priv});
    endtask

    task automatic step_model();
        if (rst_i) begin
            for (int k = 0; k < 8; k++) begin m_b0[k] = 0; m_b1[k] = 0; m_sh[k] = 0; end
            m_priv = 0; m_bank = 0;
        end else begin
            if (wr_en_i) begin
                if (wr_idx_i >= 8)            m_sh[wr_idx_i[2:0]] = wr_data_i;
                else if (m_priv && m_bank)    m_b1[wr_idx_i[2:0]] = wr_data_i;
                else                          m_b0[wr_idx_i[2:0]] = wr_data_i;
            end
            if (alt_en_i && alt_we_i && m_priv) begin
                if (m_bank) m_b0[alt_idx_i] = alt_wdata_i;
                else        m_b1[alt_idx_i] = alt_wdata_i;
            end
            m_priv = priv_i; m_bank = bank_sel_i;
        end
    endtask

    task automatic cyc(input string tag);
        #1;
        check_all(tag);
        @(posedge clk);
        step_model();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en_i = 0; alt_en_i = 0; alt_we_i = 0;
    endtask

    task automatic nwrite(input logic [3:0] idx, input logic [31:0] d, input string tag);
        idle(); wr_en_i = 1; wr_idx_i = idx; wr_data_i = d; rd_a_idx_i = idx;
        cyc(tag);
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_i = 1; priv_i = 0; bank_sel_i = 0;
        rd_a_idx_i = 0; rd_b_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
        alt_idx_i = 0; alt_wdata_i = 0;
        idle();
        repeat (2) begin @(posedge clk); step_model(); end
        @(negedge clk);
        rst_i = 0;

        // R1: all sixteen views read zero after reset
        for (int k = 0; k < 16; k++) begin rd_a_idx_i = 4'(k); rd_b_idx_i = 4'(15 - k); cyc("R1"); end
        // R1: the other bank reads zero too via the alternate port
        priv_i = 1; bank_sel_i = 0; cyc("R9");
        alt_en_i = 1;
        for (int k = 0; k < 8; k++) begin alt_idx_i = 3'(k); cyc("R1"); end
        idle();

        // R2: write R9, same-cycle read old value, next cycle new
        nwrite(4'd9, 32'hCAFE_0009, "R2");
        rd_a_idx_i = 9; cyc("R2");
        // Distinct R0 values: bank 0 via normal, bank 1 via alternate
        nwrite(4'd0, 32'hB0B0_0000, "R4");
        alt_en_i = 1; alt_we_i = 1; alt_idx_i = 0; alt_wdata_i = 32'hB1B1_0000;
        cyc("R10");
        alt_we_i = 0; cyc("R10");
        idle();
        // R9: bank bit changes, same cycle still bank 0
        bank_sel_i = 1; rd_a_idx_i = 0; cyc("R9");
        cyc("R3");
        // R7: shared write under bank 1 visible after switching back
        nwrite(4'd12, 32'h5EED_000C, "R7");
        bank_sel_i = 0; rd_a_idx_i = 12; cyc("R7");
        cyc("R7");
        // R5: user mode ignores the select bit
        priv_i = 0; bank_sel_i = 1; cyc("R9");
        rd_a_idx_i = 0; cyc("R5");
        // R6: alternate write in user mode discarded
        alt_en_i = 1; alt_we_i = 1; alt_idx_i = 0; alt_wdata_i = 32'hDEAD_BEEF;
        cyc("R6");
        idle(); priv_i = 1; bank_sel_i = 0; cyc("R6");
        alt_en_i = 1; alt_idx_i = 0; cyc("R6");
        idle();

        // Constrained random traffic
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            priv_i      = ($urandom % 8) != 0;
            if (($urandom % 6) == 0) bank_sel_i = ~bank_sel_i;
            rd_a_idx_i  = 4'($urandom);
            rd_b_idx_i  = 4'($urandom);
            wr_en_i     = $urandom % 2;
            wr_idx_i    = 4'($urandom);
            wr_data_i   = $urandom;
            alt_en_i    = ($urandom % 3) == 0;
            alt_we_i    = $urandom % 2;
            alt_idx_i   = 3'($urandom);
            alt_wdata_i = $urandom;
            cyc("");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule